// File: doc/BRIEF.md
# Multi-User Interrupting Mailbox

This block lets several processors on one chip pass 32-bit words to each other. It holds a parameterised number of small message queues, each reached through a word-wide register bus. A sender writes a queue's message register to append a word, and a receiver reads the same register to take the oldest word out. Each queue also shows, at its own register, whether it is full and how many words it holds.

Every interrupt destination ("user") has a status register, an enable-set register and an enable-clear register. Inside those registers, each queue owns two adjacent bits: the even bit flags that a new word arrived and the odd bit flags that a full queue has regained space. Events are recorded for every user whatever the enable masks hold. A user's interrupt line is raised while any of its recorded events is also enabled. Software acknowledges an event by writing a 1 to its status bit.

Top module: `ipc_mailbox`

## Requirements
- R1: After a synchronous active-high reset, every queue is empty (count register 0, full register 0), every status and enable mask is 0, and every irq line is low.
- R2: A write to the message register of queue m (byte offset 0x040+4m) appends the word. A read of that register returns the oldest word and removes it, so words come out in write order. The count register (0x0C0+4m) returns the number of words held.
- R3: The full register (0x080+4m) reads 1 while queue m holds DEPTH words and 0 otherwise. A write to a full queue is dropped and leaves its contents and count unchanged.
- R4: A read of an empty queue's message register returns 0 and changes no count, status or enable bit.
- R5: Each accepted write to queue m sets bit 2m in the status register of every user, whether or not that bit is enabled.
- R6: A read that removes a word from a full queue m sets bit 2m+1 in the status register of every user.
- R7: Writing to user u's status register (0x104+0x10u) clears the bits written as 1 and keeps the others. The next read returns the updated value. An event that arrives in the same cycle as the clear wins.
- R8: Writing to user u's enable-set register (0x108+0x10u) ORs the written bits into that user's enable mask. A read of this register returns the mask.
- R9: Writing to user u's enable-clear register (0x10C+0x10u) removes the written bits from the mask and leaves the rest unchanged. A read of this register also returns the mask.
- R10: irq[u] is high exactly when user u's status AND enable is nonzero. It follows a register update in the same cycle that the register changes.
- R11: Offset 0x000 reads the REVISION constant, and a write to it is ignored. Unmapped offsets read 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 12 | Byte address of the register accessed |
| wr_en | input | 1 | Write strobe, one access per cycle |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Read strobe; pops a message register at the clock edge |
| rdata | output | 32 | Read data, combinational from addr |
| irq | output | NUM_USERS | One interrupt line per user |

## Verification
The not-full event is the hardest case to reach. It only occurs when a word is removed from a queue that holds exactly DEPTH words, so the stimulus first fills queue 0 to the brim and offers one extra write to prove it is dropped. It then acknowledges the new-message bits, so that the single odd bit raised by the next pop stands alone in both users' status. The empty-read case is reached by draining that same queue, acknowledging again, and reading once more. The bench then confirms that the status and count stay at zero.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   localparam int ADDR_W   = 12;
   localparam int DATA_W   = 32;
   localparam int MSG_BASE = 'h040;
   localparam int FUL_BASE = 'h080;
   localparam int CNT_BASE = 'h0C0;
   localparam int USR_BASE = 'h104;
   localparam int USR_STEP = 'h10;

   function automatic logic [ADDR_W-1:0] msg_ofs(input int m);
      return ADDR_W'(MSG_BASE + 4 * m);
   endfunction
   function automatic logic [ADDR_W-1:0] ful_ofs(input int m);
      return ADDR_W'(FUL_BASE + 4 * m);
   endfunction
   function automatic logic [ADDR_W-1:0] cnt_ofs(input int m);
      return ADDR_W'(CNT_BASE + 4 * m);
   endfunction
   // k = 0 status, 1 enable-set, 2 enable-clear
   function automatic logic [ADDR_W-1:0] usr_ofs(input int u, input int k);
      return ADDR_W'(USR_BASE + USR_STEP * u + 4 * k);
   endfunction
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
   parameter int DW    = 32,
   parameter int DEPTH = 4,
   localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          push,
   input  logic          pop,
   input  logic [DW-1:0] din,
   output logic [DW-1:0] head,
   output logic [CW-1:0] count,
   output logic          full,
   output logic          push_ok,
   output logic          freed
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("mbx_fifo: DEPTH must be at least 2");
      end
   endgenerate

   logic [DW-1:0] mem [DEPTH];
   logic [PW-1:0] wptr, rptr;
   logic          pop_ok;

   assign full    = (count == CW'(DEPTH));
   assign push_ok = push && !full;
   assign pop_ok  = pop && (count != '0);
   assign freed   = pop_ok && full;
   assign head    = mem[rptr];

   function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
      return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk) begin
      if (rst) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (push_ok) begin
            mem[wptr] <= din;
            wptr      <= nxt(wptr);
         end
         if (pop_ok) rptr <= nxt(rptr);
         count <= count + CW'(push_ok) - CW'(pop_ok);
      end
   end

   // R3
   depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
      count <= CW'(DEPTH));
   // R3
   drop_full_chk: assert property (@(posedge clk) disable iff (rst)
      (push && full && !pop) |=> count == CW'(DEPTH));
   // R4
   empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
      (pop && !push && count == '0) |=> count == '0);
endmodule

// File: rtl/mbx_user_irq.sv
module mbx_user_irq #(
   parameter int NB = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [NB-1:0] ev,
   input  logic          st_w1c,
   input  logic          en_set,
   input  logic          en_clr,
   input  logic [NB-1:0] wbits,
   output logic [NB-1:0] status,
   output logic [NB-1:0] enable,
   output logic          irq
);
   always_ff @(posedge clk) begin
      if (rst) begin
         status <= '0;
         enable <= '0;
      end else begin
         status <= (status & ~(st_w1c ? wbits : '0)) | ev;
         if (en_set)      enable <= enable | wbits;
         else if (en_clr) enable <= enable & ~wbits;
      end
   end

   assign irq = |(status & enable);

   // R5
   event_capture_chk: assert property (@(posedge clk) disable iff (rst)
      (ev != '0) |=> (status & $past(ev)) == $past(ev));
   // R7
   sticky_status_chk: assert property (@(posedge clk) disable iff (rst)
      !st_w1c |=> ($past(status) & ~status) == '0);
   // R8
   enable_or_chk: assert property (@(posedge clk) disable iff (rst)
      en_set |=> (enable & $past(wbits)) == $past(wbits));
   // R9
   enable_clr_chk: assert property (@(posedge clk) disable iff (rst)
      (en_clr && !en_set) |=> ((enable & $past(wbits)) == '0) &&
                              (((enable ^ $past(enable)) & ~$past(wbits)) == '0));
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
   import mbx_pkg::*;
#(
   parameter int          NUM_FIFOS = 4,
   parameter int          NUM_USERS = 2,
   parameter int          DEPTH     = 4,
   parameter logic [31:0] REVISION  = 32'h0000_0400,
   localparam int         NB        = 2 * NUM_FIFOS,
   localparam int         CW        = $clog2(DEPTH + 1)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [ADDR_W-1:0]    addr,
   input  logic                 wr_en,
   input  logic [DATA_W-1:0]    wdata,
   input  logic                 rd_en,
   output logic [DATA_W-1:0]    rdata,
   output logic [NUM_USERS-1:0] irq
);
   generate
      if (NUM_FIFOS < 1 || NUM_FIFOS > 16) begin : g_bad_fifos
         $error("ipc_mailbox: NUM_FIFOS must be 1..16");
      end
      if (NUM_USERS < 1 || NUM_USERS > 64) begin : g_bad_users
         $error("ipc_mailbox: NUM_USERS must be 1..64");
      end
   endgenerate

   logic [NUM_FIFOS-1:0][DATA_W-1:0] head;
   logic [NUM_FIFOS-1:0][CW-1:0]     cnt;
   logic [NUM_FIFOS-1:0]             full, push_ok, freed;
   logic [NB-1:0]                    ev;
   logic [NUM_USERS-1:0][NB-1:0]     status, enable;

   for (genvar m = 0; m < NUM_FIFOS; m++) begin : g_fifo
      logic hit;
      assign hit = (addr == msg_ofs(m));
      mbx_fifo #(.DW(DATA_W), .DEPTH(DEPTH)) u_fifo (
         .clk     (clk),
         .rst     (rst),
         .push    (wr_en && hit),
         .pop     (rd_en && hit),
         .din     (wdata),
         .head    (head[m]),
         .count   (cnt[m]),
         .full    (full[m]),
         .push_ok (push_ok[m]),
         .freed   (freed[m])
      );
      assign ev[2*m]   = push_ok[m];
      assign ev[2*m+1] = freed[m];
   end

   for (genvar u = 0; u < NUM_USERS; u++) begin : g_user
      mbx_user_irq #(.NB(NB)) u_irq (
         .clk    (clk),
         .rst    (rst),
         .ev     (ev),
         .st_w1c (wr_en && addr == usr_ofs(u, 0)),
         .en_set (wr_en && addr == usr_ofs(u, 1)),
         .en_clr (wr_en && addr == usr_ofs(u, 2)),
         .wbits  (wdata[NB-1:0]),
         .status (status[u]),
         .enable (enable[u]),
         .irq    (irq[u])
      );
   end

   always_comb begin
      rdata = '0;
      if (addr == '0) rdata = REVISION;
      for (int m = 0; m < NUM_FIFOS; m++) begin
         if (addr == msg_ofs(m)) rdata = (cnt[m] != '0) ? head[m] : '0;
         if (addr == ful_ofs(m)) rdata = DATA_W'(full[m]);
         if (addr == cnt_ofs(m)) rdata = DATA_W'(cnt[m]);
      end
      for (int u = 0; u < NUM_USERS; u++) begin
         if (addr == usr_ofs(u, 0)) rdata = DATA_W'(status[u]);
         if (addr == usr_ofs(u, 1) || addr == usr_ofs(u, 2))
            rdata = DATA_W'(enable[u]);
      end
   end

   // R10
   irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (status == '0) |-> (irq == '0));
   // R6
   notfull_only_from_full_chk: assert property (@(posedge clk) disable iff (rst)
      (ev[1] == 1'b1) |-> full[0]);
endmodule

// File: tb/ipc_mailbox_tb.sv
module ipc_mailbox_tb;
   logic        clk = 0;
   logic        rst;
   logic [11:0] addr;
   logic        wr_en, rd_en;
   logic [31:0] wdata, rdata;
   logic [1:0]  irq;
   int checks = 0, errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   ipc_mailbox u_dut (.clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en),
      .wdata(wdata), .rd_en(rd_en), .rdata(rdata), .irq(irq));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk); addr = a; wdata = d; wr_en = 1;
      @(negedge clk); wr_en = 0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk); addr = a; rd_en = 1; #1 d = rdata;
      @(negedge clk); rd_en = 0;
   endtask

   task automatic rdchk(input logic [11:0] a, input logic [31:0] exp, input string tag);
      logic [31:0] d;
      rd(a, d);
      chk(tag, d, exp);
   endtask

   task automatic t_reset();
      rdchk(12'h0C0, 0, "R1 count0");
      rdchk(12'h080, 0, "R1 full0");
      rdchk(12'h104, 0, "R1 status u0");
      rdchk(12'h118, 0, "R1 enable u1");
      chk("R1 irq", 32'(irq), 0);
   endtask

   task automatic t_order();
      wr(12'h044, 32'hA1); wr(12'h044, 32'hB2); wr(12'h044, 32'hC3);
      rdchk(12'h0C4, 3, "R2 count after 3 writes");
      rdchk(12'h104, 32'h4, "R5 status u0 bit2");
      rdchk(12'h114, 32'h4, "R5 status u1 bit2");
      chk("R5 irq with no enable", 32'(irq), 0);
      rdchk(12'h044, 32'hA1, "R2 first");
      rdchk(12'h044, 32'hB2, "R2 second");
      rdchk(12'h044, 32'hC3, "R2 third");
      rdchk(12'h0C4, 0, "R2 count drained");
      wr(12'h104, 32'hFF); wr(12'h114, 32'hFF);
      rdchk(12'h104, 0, "R7 status u0 cleared");
   endtask

   task automatic t_full();
      for (int i = 0; i < 4; i++) wr(12'h040, 32'h100 + 32'(i));
      rdchk(12'h080, 1, "R3 full flag");
      wr(12'h040, 32'hDEAD);
      rdchk(12'h0C0, 4, "R3 count after dropped write");
      wr(12'h104, 32'h1); wr(12'h114, 32'h1);
      rdchk(12'h040, 32'h100, "R2 oldest of full");
      rdchk(12'h104, 32'h2, "R6 not-full u0");
      rdchk(12'h114, 32'h2, "R6 not-full u1");
      rdchk(12'h080, 0, "R3 full flag drops");
      for (int i = 1; i < 4; i++) rdchk(12'h040, 32'h100 + 32'(i), "R3 kept words");
      wr(12'h104, 32'hFF); wr(12'h114, 32'hFF);
      rdchk(12'h040, 0, "R4 empty read zero");
      rdchk(12'h0C0, 0, "R4 count stays");
      rdchk(12'h104, 0, "R4 status unchanged");
   endtask

   task automatic t_irq();
      wr(12'h118, 32'h1);
      wr(12'h040, 32'h55);
      chk("R10 irq u1 raised", 32'(irq), 32'h2);
      wr(12'h118, 32'h30);
      rdchk(12'h118, 32'h31, "R8 enable OR");
      wr(12'h11C, 32'h1);
      rdchk(12'h11C, 32'h30, "R9 enable clear keeps others");
      chk("R9 irq off after clear", 32'(irq), 0);
      wr(12'h118, 32'h1);
      chk("R10 irq back", 32'(irq), 32'h2);
      wr(12'h114, 32'h1);
      rdchk(12'h114, 0, "R7 w1c readback");
      chk("R10 irq after ack", 32'(irq), 0);
      rdchk(12'h104, 32'h1, "R7 other user untouched");
      rdchk(12'h040, 32'h55, "R2 drain");
   endtask

   task automatic t_misc();
      rdchk(12'h000, 32'h400, "R11 revision");
      wr(12'h000, 32'h1234);
      rdchk(12'h000, 32'h400, "R11 revision not writable");
      wr(12'h200, 32'hFFFF); wr(12'h100, 32'hFF); wr(12'h0FC, 32'hFF);
      rdchk(12'h200, 0, "R11 unmapped reads zero");
      rdchk(12'h100, 0, "R11 gap reads zero");
      rdchk(12'h104, 32'h1, "R11 status unchanged");
      rdchk(12'h108, 0, "R11 enable unchanged");
      rdchk(12'h0C0, 0, "R11 count unchanged");
   endtask

   initial begin
      rst = 1; addr = 0; wr_en = 0; rd_en = 0; wdata = 0;
      repeat (3) @(negedge clk);
      rst = 0;
      t_reset();
      t_order();
      t_full();
      t_irq();
      t_misc();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule